// File: doc/BRIEF.md
# Serial Controller Register and Status Block

This block is the register front end of a simple serial controller. A processor reaches it through a single-cycle bus port. It decodes byte offsets inside a small window and keeps the controller's configuration registers: mode, bit rate, control, FIFO control and port. It also keeps five sticky status flags and drives a transmit interrupt request.

Writing the transmit data offset emits a one-cycle strobe. The strobe carries the byte to a downstream shifter. A receive count from an external receive path is only reported back on reads. The shifters, the baud generator and the receive storage sit outside this block.

A static parameter selects the FIFO-capable feature set. With it set, the block masks some mode and control bits, exposes the status, FIFO control, receive count, port and line status registers, and drives the interrupt from a control bit. With it clear, only the four common registers decode.

Top module: `sercom_regfile`

## Requirements
- R1: After reset the registers read as follows: mode 0x00, bit rate 0xFF, control 0x20, FIFO control 0x00, port 0x00, status 0x60. The transmit data register reads 0x00 with the FIFO feature set and 0xFF without it. The interrupt request, the error pulse and the transmit strobe are low.
- R2: Read data appears on `bus_rdata` in the cycle after the read strobe, and it holds until the next read.
- R3: With the FIFO feature set, a mode write stores `wdata & 0x7B` and a control write stores `wdata & 0xFA`. Without the feature set, both registers store all 8 bits.
- R4: A write to offset 0x0C latches the byte. In the following cycle `tx_strobe` is high for exactly one cycle with that byte on `tx_byte`. The write also clears the transmit-data-empty flag (status bit 5).
- R5: With the FIFO feature set, `tx_irq` takes the value of control write data bit 7 in the cycle after the control write, and holds otherwise. Without the feature set, `tx_irq` stays low.
- R6: A control write with bit 5 (transmit enable) clear sets the transmit-end flag (status bit 6).
- R7: The status register sits at offset 0x10. Its bits are: transmit end bit 6, transmit data empty bit 5, break bit 4, receive full bit 1, data ready bit 0; every other bit reads 0. A status write clears each flag whose bit is written 0 and leaves each flag whose bit is written 1.
- R8: A status read returns the flags as they were before the read. If control bit 5 is set, the read then sets the transmit-end and transmit-data-empty flags. If control bit 5 is clear, the read changes nothing.
- R9: The other FIFO-mode offsets behave as follows. Offset 0x1C returns the `rx_count` input, zero-extended. Offsets 0x18 (FIFO control) and 0x20 (port) read back what was written. Offset 0x24 reads 0x00 and ignores writes. Offset 0x04 (bit rate) reads back what was written in both modes.
- R10: An access to an undecoded offset gives `bus_err` high for one cycle, in the cycle after the access. Undecoded offsets are misaligned offsets, 0x14, offsets from 0x28 up, and the FIFO-only offsets 0x10 to 0x24 when the feature set is off. Such an access changes no state, and such a read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| bus_err | output | 1 | Undecoded access pulse |
| rx_count | input | CNT_W | Receive count to report |
| tx_strobe | output | 1 | Transmit byte valid pulse |
| tx_byte | output | 8 | Last byte written for transmit |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
Every result of this block is due one clock edge after the access that causes it: read data, the error pulse, the transmit strobe and the interrupt level. Flag updates become visible on the next status read. The bench drives each access just after a falling edge and withdraws it at the following falling edge. It samples the outputs at that second falling edge, a full half cycle after the capturing rising edge. The single-cycle width of the strobe and the error pulse is confirmed one falling edge later. Re-arming on a status read is checked with two back-to-back reads: the first shows the pre-read value and the second shows the re-armed flags.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
    localparam int BYTE_W = 8;
    localparam int OFFS_W = 6;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_MODE, SEL_BRATE, SEL_CTRL, SEL_TXD,
        SEL_STAT, SEL_FCTL, SEL_RXCNT, SEL_PORT, SEL_LINE
    } sel_e;

    localparam logic [BYTE_W-1:0] MODE_KEEP_FIFO = 8'h7B;
    localparam logic [BYTE_W-1:0] CTRL_KEEP_FIFO = 8'hFA;
    localparam logic [BYTE_W-1:0] RST_BRATE      = 8'hFF;
    localparam logic [BYTE_W-1:0] RST_CTRL       = 8'h20;

    localparam int CTRL_TXEN = 5;
    localparam int CTRL_TIE  = 7;

    // status bit positions, decoded by software
    localparam int ST_TEND = 6;
    localparam int ST_TDE  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_RXF  = 1;
    localparam int ST_DRDY = 0;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic rxf;
        logic drdy;
    } flags_t;

    function automatic logic [BYTE_W-1:0] stat_image(flags_t f);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[ST_TEND] = f.tend;
        b[ST_TDE]  = f.tde;
        b[ST_BRK]  = f.brk;
        b[ST_RXF]  = f.rxf;
        b[ST_DRDY] = f.drdy;
        return b;
    endfunction
endpackage

// File: rtl/sercom_addr_decode.sv
module sercom_addr_decode
    import sercom_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1
) (
    input  logic [OFFS_W-1:0] addr,
    output sel_e              sel,
    output logic              hit
);
    always_comb begin
        sel = SEL_NONE;
        case (addr)
            6'h00: sel = SEL_MODE;
            6'h04: sel = SEL_BRATE;
            6'h08: sel = SEL_CTRL;
            6'h0C: sel = SEL_TXD;
            6'h10: sel = FIFO_MODE ? SEL_STAT  : SEL_NONE;
            6'h18: sel = FIFO_MODE ? SEL_FCTL  : SEL_NONE;
            6'h1C: sel = FIFO_MODE ? SEL_RXCNT : SEL_NONE;
            6'h20: sel = FIFO_MODE ? SEL_PORT  : SEL_NONE;
            6'h24: sel = FIFO_MODE ? SEL_LINE  : SEL_NONE;
            default: sel = SEL_NONE;
        endcase
        hit = (sel != SEL_NONE);
    end
endmodule

// File: rtl/sercom_status_flags.sv
module sercom_status_flags
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_tend,
    input  logic              clr_tde,
    input  logic              rearm,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_keep,
    output flags_t            flags_q
);
    flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d.tend = flags_q.tend & wr_keep[ST_TEND];
            flags_d.tde  = flags_q.tde  & wr_keep[ST_TDE];
            flags_d.brk  = flags_q.brk  & wr_keep[ST_BRK];
            flags_d.rxf  = flags_q.rxf  & wr_keep[ST_RXF];
            flags_d.drdy = flags_q.drdy & wr_keep[ST_DRDY];
        end
        if (set_tend) flags_d.tend = 1'b1;
        if (clr_tde)  flags_d.tde  = 1'b0;
        if (rearm) begin
            flags_d.tend = 1'b1;
            flags_d.tde  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '{tend: 1'b1, tde: 1'b1, brk: 1'b0, rxf: 1'b0, drdy: 1'b0};
        end else begin
            flags_q <= flags_d;
        end
    end
endmodule

// File: rtl/sercom_regfile.sv
module sercom_regfile
    import sercom_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1,
    parameter int CNT_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [OFFS_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic [CNT_W-1:0]  rx_count,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_irq
);
    localparam logic [BYTE_W-1:0] MODE_KEEP = FIFO_MODE ? MODE_KEEP_FIFO : '1;
    localparam logic [BYTE_W-1:0] CTRL_KEEP = FIFO_MODE ? CTRL_KEEP_FIFO : '1;
    localparam logic [BYTE_W-1:0] RST_TXD   = FIFO_MODE ? '0 : '1;

    typedef struct packed {
        logic [BYTE_W-1:0] mode;
        logic [BYTE_W-1:0] brate;
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] txd;
        logic [BYTE_W-1:0] fctl;
        logic [BYTE_W-1:0] port;
        logic [BYTE_W-1:0] rdata;
        logic              err;
        logic              strobe;
        logic              irq;
    } regs_t;

    regs_t  regs_d, regs_q;
    sel_e   sel;
    logic   hit;
    logic   rd, wr;
    flags_t flags_q;

    sercom_addr_decode #(.FIFO_MODE(FIFO_MODE)) dec_i (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    assign rd = bus_valid && !bus_write;
    assign wr = bus_valid &&  bus_write;

    sercom_status_flags flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_tend (wr && sel == SEL_CTRL && !bus_wdata[CTRL_TXEN]),
        .clr_tde  (wr && sel == SEL_TXD),
        .rearm    (rd && sel == SEL_STAT && regs_q.ctrl[CTRL_TXEN]),
        .wr_en    (wr && sel == SEL_STAT),
        .wr_keep  (bus_wdata),
        .flags_q  (flags_q)
    );

    always_comb begin
        regs_d        = regs_q;
        regs_d.err    = bus_valid && !hit;
        regs_d.strobe = 1'b0;
        if (wr) begin
            case (sel)
                SEL_MODE:  regs_d.mode  = bus_wdata & MODE_KEEP;
                SEL_BRATE: regs_d.brate = bus_wdata;
                SEL_CTRL: begin
                    regs_d.ctrl = bus_wdata & CTRL_KEEP;
                    if (FIFO_MODE) regs_d.irq = bus_wdata[CTRL_TIE];
                end
                SEL_TXD: begin
                    regs_d.txd    = bus_wdata;
                    regs_d.strobe = 1'b1;
                end
                SEL_FCTL:  regs_d.fctl  = bus_wdata;
                SEL_PORT:  regs_d.port  = bus_wdata;
                default:   ;
            endcase
        end
        if (rd) begin
            case (sel)
                SEL_MODE:  regs_d.rdata = regs_q.mode;
                SEL_BRATE: regs_d.rdata = regs_q.brate;
                SEL_CTRL:  regs_d.rdata = regs_q.ctrl;
                SEL_TXD:   regs_d.rdata = regs_q.txd;
                SEL_STAT:  regs_d.rdata = stat_image(flags_q);
                SEL_FCTL:  regs_d.rdata = regs_q.fctl;
                SEL_RXCNT: regs_d.rdata = BYTE_W'(rx_count);
                SEL_PORT:  regs_d.rdata = regs_q.port;
                SEL_LINE:  regs_d.rdata = '0;
                default:   regs_d.rdata = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q       <= '0;
            regs_q.brate <= RST_BRATE;
            regs_q.ctrl  <= RST_CTRL;
            regs_q.txd   <= RST_TXD;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_rdata = regs_q.rdata;
    assign bus_err   = regs_q.err;
    assign tx_strobe = regs_q.strobe;
    assign tx_byte   = regs_q.txd;
    assign tx_irq    = regs_q.irq;
endmodule

// File: rtl/sercom_regfile_chk.sv
module sercom_regfile_chk
    import sercom_pkg::*;
#(
    parameter bit FIFO_MODE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [OFFS_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              bus_err,
    input logic              tx_strobe,
    input logic              tx_irq
);
    // R4: a strobe only follows a transmit data write
    p_strobe_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_valid && bus_write && bus_addr == 6'h0C));

    // R4: a transmit data write always yields a strobe
    p_strobe_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 6'h0C) |=> tx_strobe);

    // R5: interrupt follows control bit 7 when the FIFO set is on
    p_irq_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (FIFO_MODE && bus_valid && bus_write && bus_addr == 6'h08)
            |=> (tx_irq == $past(bus_wdata[CTRL_TIE])));

    // R5: interrupt level holds without a control write
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_addr == 6'h08) |=> $stable(tx_irq));

    // R5: no interrupt without the FIFO set
    p_irq_plain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !FIFO_MODE |-> !tx_irq);

    // R10: the gap offset errors and reads all ones
    p_gap_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 6'h14) |=> (bus_err && bus_rdata == 8'hFF));

    // R10: aligned decoded offsets never error
    p_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_addr[1:0] == 2'b00 && bus_addr <= 6'h0C) |=> !bus_err);

    // R9: line status reads zero
    p_line_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (FIFO_MODE && bus_valid && !bus_write && bus_addr == 6'h24) |=> (bus_rdata == 8'h00));

    // R2: read data holds when no read is made
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind sercom_regfile sercom_regfile_chk #(.FIFO_MODE(FIFO_MODE)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .tx_strobe (tx_strobe),
    .tx_irq    (tx_irq)
);

// File: tb/sercom_regfile_tb_top.sv
module sercom_regfile_tb_top;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid = 1'b0;
    logic             write = 1'b0;
    logic [5:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic [CNT_W-1:0] rx_count = '0;
    logic             tgt = 1'b0;   // 0: FIFO instance, 1: plain instance

    logic [7:0] f_rdata, p_rdata, f_byte, p_byte;
    logic       f_err, p_err, f_stb, p_stb, f_irq, p_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sercom_regfile #(.FIFO_MODE(1'b1), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid && !tgt), .bus_write(write),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(f_rdata), .bus_err(f_err),
        .rx_count(rx_count), .tx_strobe(f_stb), .tx_byte(f_byte), .tx_irq(f_irq)
    );

    sercom_regfile #(.FIFO_MODE(1'b0), .CNT_W(CNT_W)) dut_plain_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(valid && tgt), .bus_write(write),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(p_rdata), .bus_err(p_err),
        .rx_count(rx_count), .tx_strobe(p_stb), .tx_byte(p_byte), .tx_irq(p_irq)
    );

    wire [7:0] o_rdata = tgt ? p_rdata : f_rdata;
    wire       o_err   = tgt ? p_err   : f_err;
    wire       o_stb   = tgt ? p_stb   : f_stb;
    wire [7:0] o_byte  = tgt ? p_byte  : f_byte;
    wire       o_irq   = tgt ? p_irq   : f_irq;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b0; addr = a;
        @(negedge clk);
        valid = 1'b0;
        d = o_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        do_read(a, v);
        chk(req, v, exp);
        chk({req, " no error"}, {7'd0, o_err}, 8'd0);
    endtask

    task automatic t_reset();
        tgt = 1'b0;
        chk("R1 irq", {7'd0, o_irq}, 8'd0);
        chk("R1 strobe", {7'd0, o_stb}, 8'd0);
        chk("R1 err", {7'd0, o_err}, 8'd0);
        rd_chk("R1 mode", 6'h00, 8'h00);
        rd_chk("R1 brate", 6'h04, 8'hFF);
        rd_chk("R1 ctrl", 6'h08, 8'h20);
        rd_chk("R1 txd fifo", 6'h0C, 8'h00);
        rd_chk("R1 fctl", 6'h18, 8'h00);
        rd_chk("R1 port", 6'h20, 8'h00);
        rd_chk("R1 status", 6'h10, 8'h60);
        tgt = 1'b1;
        rd_chk("R1 txd plain", 6'h0C, 8'hFF);
        tgt = 1'b0;
    endtask

    task automatic t_masks();
        do_write(6'h00, 8'hFF);
        rd_chk("R3 mode mask", 6'h00, 8'h7B);
        do_write(6'h08, 8'hFF);
        chk("R5 irq set", {7'd0, o_irq}, 8'd1);
        rd_chk("R3 ctrl mask", 6'h08, 8'hFA);
        chk("R5 irq holds", {7'd0, o_irq}, 8'd1);
        do_write(6'h08, 8'h20);
        chk("R5 irq clear", {7'd0, o_irq}, 8'd0);
    endtask

    task automatic t_txdata();
        do_write(6'h0C, 8'hA5);
        chk("R4 strobe", {7'd0, o_stb}, 8'd1);
        chk("R4 byte", o_byte, 8'hA5);
        @(negedge clk);
        chk("R4 strobe single", {7'd0, o_stb}, 8'd0);
        rd_chk("R4 tde cleared / R8 pre-read", 6'h10, 8'h40);
        rd_chk("R8 rearmed", 6'h10, 8'h60);
    endtask

    task automatic t_status();
        do_write(6'h08, 8'h00);
        do_write(6'h10, 8'hBF);
        rd_chk("R7 clear tend only", 6'h10, 8'h20);
        rd_chk("R8 no rearm", 6'h10, 8'h20);
        do_write(6'h10, 8'h00);
        rd_chk("R7 clear all", 6'h10, 8'h00);
        do_write(6'h08, 8'h00);
        rd_chk("R6 tend set", 6'h10, 8'h40);
        do_write(6'h10, 8'hFF);
        rd_chk("R7 ones keep", 6'h10, 8'h40);
        do_write(6'h08, 8'h20);
        rd_chk("R6 tend kept with txen", 6'h10, 8'h40);
        rd_chk("R8 rearm both", 6'h10, 8'h60);
    endtask

    task automatic t_misc();
        rx_count = 5'd19;
        rd_chk("R9 rx count", 6'h1C, 8'h13);
        do_write(6'h20, 8'h3C);
        rd_chk("R9 port", 6'h20, 8'h3C);
        do_write(6'h18, 8'h0F);
        rd_chk("R9 fctl", 6'h18, 8'h0F);
        do_write(6'h24, 8'hFF);
        rd_chk("R9 line", 6'h24, 8'h00);
        do_write(6'h04, 8'h1A);
        rd_chk("R9 brate", 6'h04, 8'h1A);
        rd_chk("R2 rdata holds", 6'h04, 8'h1A);
        @(negedge clk);
        chk("R2 rdata idle hold", o_rdata, 8'h1A);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        do_read(6'h14, v);
        chk("R10 gap read data", v, 8'hFF);
        chk("R10 gap err", {7'd0, o_err}, 8'd1);
        @(negedge clk);
        chk("R10 err single", {7'd0, o_err}, 8'd0);
        do_write(6'h01, 8'h55);
        chk("R10 misaligned err", {7'd0, o_err}, 8'd1);
        rd_chk("R10 mode untouched", 6'h00, 8'h7B);
        do_read(6'h28, v);
        chk("R10 high read data", v, 8'hFF);
        chk("R10 high err", {7'd0, o_err}, 8'd1);
    endtask

    task automatic t_plain();
        logic [7:0] v;
        tgt = 1'b1;
        do_write(6'h00, 8'hFF);
        rd_chk("R3 plain mode", 6'h00, 8'hFF);
        do_write(6'h08, 8'hFF);
        chk("R5 plain irq low", {7'd0, o_irq}, 8'd0);
        rd_chk("R3 plain ctrl", 6'h08, 8'hFF);
        do_read(6'h10, v);
        chk("R10 plain status data", v, 8'hFF);
        chk("R10 plain status err", {7'd0, o_err}, 8'd1);
        do_write(6'h20, 8'h11);
        chk("R10 plain port err", {7'd0, o_err}, 8'd1);
        do_read(6'h1C, v);
        chk("R10 plain count data", v, 8'hFF);
        do_write(6'h0C, 8'h3E);
        chk("R4 plain strobe", {7'd0, o_stb}, 8'd1);
        chk("R4 plain byte", o_byte, 8'h3E);
        tgt = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masks();
        t_txdata();
        t_status();
        t_misc();
        t_errors();
        t_plain();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule